// File: doc/BRIEF.md
# Command-Phase Register Port

This block is a slave on a 16-bit microprocessor bus. Two I/O locations are exposed, and one address line chooses between them. The host first writes a command code to the command location. The code's low seven bits select an internal target, and bit 7 gives the direction. The host then performs one or more 16-bit data phases at the data location. Each target sets its own number of phases: one for a plain 16-bit register, two for a 32-bit register, and a variable count for the streaming buffer ports.

The targets are a small file of 16-bit registers, a few 32-bit registers, a byte-count register, a read-only identity word, a reset-key register, and two buffer memories. Each buffer streams consecutive words from its start. The number of words in a buffer access comes from the byte-count register. A correct key word written to the reset-key register returns every register to its reset value. The buffer memories keep their contents.

Top module: `cmd_reg_port`

## Requirements
- R1: A write strobe with `cs` high and `addr` = 1 is a command. Bits [6:0] name the target and bit 7 = 1 marks a write. The read code of a target is its write code with bit 7 clear. Bits [15:8] are ignored.
- R2: Codes 00h to 0Fh are 16-bit read/write registers, and each command takes exactly one data phase.
- R3: Codes 10h to 13h are 32-bit read/write registers. Each takes two data phases, lower word first. A write updates the register only when the upper word arrives.
- R4: Read code 27h returns 61h in bits [15:8] and the revision parameter in bits [7:0]. A data phase under write code A7h changes nothing.
- R5: Writing 00F6h under code A9h resets every register, including the byte count, to zero. Buffer contents are kept. Any other value under A9h has no effect. Reading under 29h returns 0000h.
- R6: Code 22h/A2h is a 16-bit byte-count register that reads back what was written.
- R7: Codes 40h/C0h (buffer A) and 41h/C1h (buffer B) accept ceil(count/2) data phases, capped at the buffer depth (64 words by default). Each buffer access starts at word 0 and steps by one word per phase. A count of zero gives no phases.
- R8: A data phase is ignored on write, and returns 0000h on read, in three cases: no command is pending, the pending command's phases are all used, or the code is unassigned.
- R9: A new command abandons any unfinished sequence and restarts the phase count. A half-written 32-bit register keeps its old value.
- R10: A data phase whose direction differs from the pending command's direction is ignored, returns 0000h, and does not consume a phase.
- R11: Strobes with `cs` low have no effect. After reset all registers read zero and no command is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| addr | input | 1 | 1 = command location, 0 = data location |
| wr_en | input | 1 | Write strobe, one cycle per phase |
| rd_en | input | 1 | Read strobe, one cycle per phase (ignored while wr_en is high) |
| wdata | input | 16 | Write data or command code |
| rdata | output | 16 | Read data, valid in the cycle of a read strobe |

## Verification
Two things can happen on the same clock edge.

- **Reset key.** The data phase that carries the reset key also ends its one-phase sequence. On that edge the register file is cleared and the command retires together. The bench writes the key, then at once reads a cleared register, the byte count and a buffer word that was stored beforehand. The register and the count must read zero, and the buffer word must be unchanged.
- **Buffer length.** The buffer phase count is fixed when the command is taken, so a byte-count write does not disturb a buffer sequence already under way. The bench checks this by re-issuing buffer commands after count changes and counting how many phases are accepted before reads return zero.

// File: rtl/cmd_reg_port.sv
module cmd_reg_port #(
  parameter int         NUM16     = 16,
  parameter int         NUM32     = 4,
  parameter int         BUF_WORDS = 64,
  parameter logic [7:0] REV       = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);

  localparam int I16W = (NUM16 > 1) ? $clog2(NUM16) : 1;
  localparam int I32W = (NUM32 > 1) ? $clog2(NUM32) : 1;
  localparam int BAW  = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
  localparam logic [6:0]  R32_BASE = 7'h10;
  localparam logic [6:0]  CNT_IDX  = 7'h22;
  localparam logic [6:0]  ID_IDX   = 7'h27;
  localparam logic [6:0]  SRST_IDX = 7'h29;
  localparam logic [6:0]  BUFA_IDX = 7'h40;
  localparam logic [6:0]  BUFB_IDX = 7'h41;
  localparam logic [15:0] SRST_KEY = 16'h00F6;
  localparam logic [15:0] BUF_CAP  = 16'(BUF_WORDS);
  localparam logic [15:0] ID_WORD  = {8'h61, REV};

  typedef enum logic [2:0] {K_NONE, K_R16, K_R32, K_CNT, K_ID, K_SRST, K_BUF} kind_t;

  function automatic kind_t decode(input logic [6:0] i);
    if (int'(i) < NUM16)                                         return K_R16;
    if (i >= R32_BASE && int'(i) < int'(R32_BASE) + NUM32)       return K_R32;
    if (i == CNT_IDX)                                            return K_CNT;
    if (i == ID_IDX)                                             return K_ID;
    if (i == SRST_IDX)                                           return K_SRST;
    if (i == BUFA_IDX || i == BUFB_IDX)                          return K_BUF;
    return K_NONE;
  endfunction

  logic        cmd_ok, cmd_dir;
  logic [6:0]  cmd_idx;
  kind_t       cmd_kind;
  logic [15:0] need, phase, lo_stage, xfer_cnt;
  logic [15:0] r16 [NUM16];
  logic [31:0] r32 [NUM32];
  logic [15:0] bmem [2][BUF_WORDS];

  wire cmd_stb = cs & addr & wr_en;
  wire data_wr = cs & ~addr & wr_en;
  wire data_rd = cs & ~addr & rd_en & ~wr_en;
  wire take    = cmd_ok & ((data_wr & cmd_dir) | (data_rd & ~cmd_dir));
  wire wtake   = take & cmd_dir;
  wire last    = (phase == need - 16'd1);
  wire srst_hit = wtake && cmd_kind == K_SRST && wdata == SRST_KEY;

  kind_t       new_kind;
  logic [16:0] words_raw;
  logic [15:0] words, need_new;

  always_comb begin
    new_kind  = decode(wdata[6:0]);
    words_raw = ({1'b0, xfer_cnt} + 17'd1) >> 1;
    words     = (words_raw > {1'b0, BUF_CAP}) ? BUF_CAP : words_raw[15:0];
    case (new_kind)
      K_R16, K_CNT, K_ID, K_SRST: need_new = 16'd1;
      K_R32:                      need_new = 16'd2;
      K_BUF:                      need_new = words;
      default:                    need_new = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_ok   <= 1'b0;
      cmd_dir  <= 1'b0;
      cmd_idx  <= '0;
      cmd_kind <= K_NONE;
      need     <= '0;
      phase    <= '0;
    end else if (cmd_stb) begin
      cmd_ok   <= (need_new != 16'd0);
      cmd_dir  <= wdata[7];
      cmd_idx  <= wdata[6:0];
      cmd_kind <= new_kind;
      need     <= need_new;
      phase    <= '0;
    end else if (take) begin
      phase <= phase + 16'd1;
      if (last) cmd_ok <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM16; i++) r16[i] <= '0;
      for (int i = 0; i < NUM32; i++) r32[i] <= '0;
      xfer_cnt <= '0;
      lo_stage <= '0;
    end else if (srst_hit) begin
      for (int i = 0; i < NUM16; i++) r16[i] <= '0;
      for (int i = 0; i < NUM32; i++) r32[i] <= '0;
      xfer_cnt <= '0;
      lo_stage <= '0;
    end else if (wtake) begin
      case (cmd_kind)
        K_R16: r16[cmd_idx[I16W-1:0]] <= wdata;
        K_R32: begin
          if (phase[0] == 1'b0) lo_stage <= wdata;
          else                  r32[cmd_idx[I32W-1:0]] <= {wdata, lo_stage};
        end
        K_CNT:   xfer_cnt <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wtake && cmd_kind == K_BUF)
      bmem[cmd_idx[0]][phase[BAW-1:0]] <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (take && !cmd_dir) begin
      case (cmd_kind)
        K_R16:   rdata = r16[cmd_idx[I16W-1:0]];
        K_R32:   rdata = phase[0] ? r32[cmd_idx[I32W-1:0]][31:16]
                                  : r32[cmd_idx[I32W-1:0]][15:0];
        K_CNT:   rdata = xfer_cnt;
        K_ID:    rdata = ID_WORD;
        K_BUF:   rdata = bmem[cmd_idx[0]][phase[BAW-1:0]];
        default: rdata = '0;
      endcase
    end
  end

  a_r9_cmd_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> (phase == 16'd0));

  a_r8_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |-> (phase < need));

  a_r8_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (take && last) |=> !cmd_ok);

  a_r7_buf_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && cmd_kind == K_BUF) |-> (need <= BUF_CAP && need != 16'd0));

  a_r5_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> (xfer_cnt == 16'd0));

  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wtake && cmd_kind == K_CNT) && !srst_hit) |=> $stable(xfer_cnt));

  a_r10_dir_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && ((data_wr && !cmd_dir) || (data_rd && cmd_dir))) |=> $stable(phase));

  a_r11_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ($stable(phase) && $stable(cmd_ok)));

endmodule

// File: tb/cmd_reg_port_tb.sv
module cmd_reg_port_tb;
  localparam int CLK_P = 10;
  localparam int BUFW  = 64;
  localparam logic [7:0] REV = 8'h02;

  logic clk = 0, rst_n = 0, cs = 0, addr = 0, wr_en = 0, rd_en = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;

  cmd_reg_port #(.NUM16(16), .NUM32(4), .BUF_WORDS(BUFW), .REV(REV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata));

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [15:0] got;
  logic [15:0] m16 [16];
  logic [31:0] m32 [4];
  logic [15:0] mcnt;
  logic [15:0] mbuf [2][BUFW];

  function automatic int exp_words(input logic [15:0] c);
    int w = (int'(c) + 1) / 2;
    return (w > BUFW) ? BUFW : w;
  endfunction

  task automatic check(input string tag, input logic [15:0] g, input logic [15:0] e);
    n_run++;
    if (g !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, g, e);
    end
  endtask

  task automatic bus(input logic c, input logic a, input logic w, input logic r, input logic [15:0] d);
    @(negedge clk);
    cs = c; addr = a; wr_en = w; rd_en = r; wdata = d;
    #(CLK_P/4) got = rdata;
    @(posedge clk);
    #1 cs = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic cmd(input logic [7:0] c);  bus(1, 1, 1, 0, {8'h00, c}); endtask
  task automatic dw(input logic [15:0] d);  bus(1, 0, 1, 0, d);          endtask
  task automatic dr(input string tag, input logic [15:0] e);
    bus(1, 0, 0, 1, 16'h0);
    check(tag, got, e);
  endtask

  task automatic fill_buf(input int b, input int n, input logic [15:0] seed);
    cmd(b ? 8'hC1 : 8'hC0);
    for (int k = 0; k < n; k++) begin
      logic [15:0] v = seed + 16'(k * 3);
      dw(v);
      if (k < exp_words(mcnt)) mbuf[b][k] = v;
    end
  endtask

  task automatic read_buf(input string tag, input int b, input int n);
    cmd(b ? 8'h41 : 8'h40);
    for (int k = 0; k < n; k++)
      dr(tag, (k < exp_words(mcnt)) ? mbuf[b][k] : 16'h0000);
  endtask

  task automatic set_cnt(input logic [15:0] c);
    cmd(8'hA2); dw(c); mcnt = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) m16[i] = 0;
    for (int i = 0; i < 4; i++) m32[i] = 0;
    mcnt = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R11 / R8: reset state, no command pending
    dr("R8 read with no command", 16'h0000);
    cmd(8'h05); dr("R11 reset value reg5", 16'h0000);
    cmd(8'h22); dr("R11 reset byte count", 16'h0000);
    // R4 identity
    cmd(8'h27); dr("R4 identity word", {8'h61, REV});

    // R1 R2 random 16-bit traffic
    for (int n = 0; n < 30; n++) begin
      int i = int'($urandom % 16);
      logic [15:0] v = 16'($urandom);
      cmd(8'h80 | 8'(i)); dw(v); m16[i] = v;
      i = int'($urandom % 16);
      cmd(8'(i)); dr("R2 16-bit readback", m16[i]);
    end
    // R1: upper command bits ignored
    cmd(8'h83); dw(16'hBEEF); m16[3] = 16'hBEEF;
    bus(1, 1, 1, 0, 16'hFF03); dr("R1 high command byte ignored", 16'hBEEF);

    // R3 32-bit, lower word first
    for (int n = 0; n < 8; n++) begin
      int j = int'($urandom % 4);
      logic [31:0] v = $urandom;
      cmd(8'h90 + 8'(j)); dw(v[15:0]); dw(v[31:16]); m32[j] = v;
      cmd(8'h10 + 8'(j));
      dr("R3 low word first", m32[j][15:0]);
      dr("R3 high word second", m32[j][31:16]);
    end

    // R9 abandoned 32-bit write leaves old value
    cmd(8'h91); dw(16'h1111);
    cmd(8'h11);
    dr("R9 abandoned write low", m32[1][15:0]);
    dr("R9 abandoned write high", m32[1][31:16]);
    // R9 read sequence restarted at low word
    cmd(8'h12); dr("R9 partial read", m32[2][15:0]);
    cmd(8'h12); dr("R9 restart low word", m32[2][15:0]);

    // R4 write to identity ignored
    cmd(8'hA7); dw(16'h0000);
    cmd(8'h27); dr("R4 identity after write", {8'h61, REV});

    // R8 extra phase after completion, unknown code
    cmd(8'h86); dw(16'hAAAA); dw(16'h5555); m16[6] = 16'hAAAA;
    cmd(8'h06); dr("R8 extra write phase ignored", 16'hAAAA);
    dr("R8 extra read phase", 16'h0000);
    cmd(8'h7E); dr("R8 unknown code read", 16'h0000);

    // R10 direction mismatch
    cmd(8'h87); dr("R10 read under write command", 16'h0000);
    dw(16'h7777); m16[7] = 16'h7777;
    cmd(8'h07); dw(16'h9999);
    dr("R10 write under read command ignored", 16'h7777);

    // R11 cs low
    cmd(8'h88); bus(0, 0, 1, 0, 16'hDEAD);
    dw(16'h0123); m16[8] = 16'h0123;
    cmd(8'h08); dr("R11 cs low ignored", 16'h0123);

    // R6 byte count
    set_cnt(16'h0050);
    cmd(8'h22); dr("R6 byte count readback", 16'h0050);

    // R7 buffers
    fill_buf(0, 41, 16'h1000);
    read_buf("R7 buffer A 50h bytes", 0, 41);
    set_cnt(16'h0005);
    fill_buf(1, 4, 16'h2000);
    read_buf("R7 buffer B odd count", 1, 4);
    set_cnt(16'hFFFF);
    fill_buf(1, BUFW + 1, 16'h3000);
    read_buf("R7 buffer B capped", 1, BUFW + 1);
    set_cnt(16'h0000);
    read_buf("R7 zero count", 0, 1);
    set_cnt(16'h0050);
    read_buf("R7 buffer A untouched by B", 0, 4);

    // R5 reset key
    cmd(8'hA9); dw(16'h1234);
    cmd(8'h06); dr("R5 wrong key no effect", m16[6]);
    cmd(8'h29); dr("R5 key register reads zero", 16'h0000);
    cmd(8'hA9); dw(16'h00F6);
    for (int i = 0; i < 16; i++) m16[i] = 0;
    for (int i = 0; i < 4; i++) m32[i] = 0;
    mcnt = 0;
    cmd(8'h06); dr("R5 register cleared", 16'h0000);
    cmd(8'h13); dr("R5 32-bit cleared", 16'h0000);
    cmd(8'h22); dr("R5 count cleared", 16'h0000);
    set_cnt(16'h0008);
    read_buf("R5 buffer kept", 0, 4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule